// File: doc/BRIEF.md
# Packet-Committing Slave FIFO Endpoint

This block is the device side of a synchronous slave FIFO write port. An external master drives an active-low chip select, an active-low write strobe, an active-low packet-end, a small thread address and a data word. All of them are sampled on the rising edge of the interface clock. Each thread has its own word buffer and a small queue of packet lengths. A write stores one word in the addressed thread. A packet-end closes the packet that thread has open, and a packet-end with no word closes an empty packet.

Closed packets leave on a downstream valid/ready stream. Each beat carries the thread number, the packet word count, one data word and a last marker. Empty, full and partial flags go back to the master for flow control. One flag set follows the addressed thread and one watches a thread fixed by a parameter. Both sets pass through a fixed register pipeline. Writes that cannot be stored are dropped, and each such drop is recorded in a sticky per-thread overflow bit.

Top module: `sfe_slave_fifo`

## Requirements
- R1: On a rising edge where cs_ni and wr_ni are both low, data_i is stored in thread addr_i. Each thread delivers its words downstream in the order they were written.
- R2: A write with pkt_end_ni low closes the open packet of that thread, including the word written in that cycle. The packet is delivered even if it is shorter than the buffer. Every beat of the packet reports its word count on out_count_o.
- R3: pkt_end_ni low with cs_ni low and wr_ni high closes a zero-length packet on thread addr_i. It is delivered as one beat with out_count_o = 0, out_data_o = 0 and out_last_o = 1.
- R4: While cs_ni is high, wr_ni, pkt_end_ni, addr_i and data_i have no effect on any thread.
- R5: A request that cannot complete is dropped whole and sets overflow_o[thread]. This covers a write to a thread holding DEPTH words, and a packet-end on a thread whose length queue holds LEN_DEPTH packets. The overflow bit stays 1 until reset.
- R6: A thread's status is defined by its word count, which includes stored words not yet delivered. Empty means the count is 0. Full means the count is DEPTH or the length queue is full. Partial means DEPTH minus the count is at or below that thread's PART_THR entry. Every PART_THR entry is below DEPTH.
- R7: After edge t+2, the flag_cur_* outputs show the status of the thread sampled on addr_i at edge t, as it stood just before edge t. Flags are therefore valid three edges after an address change.
- R8: The flag_ded_* outputs follow the same timing for thread DED_THR, whatever addr_i is.
- R9: A beat transfers on a rising edge where out_valid_o and out_ready_i are both high. While out_valid_o is high and out_ready_i is low, the thread, count and data of the beat stay unchanged.
- R10: When no packet is in progress, the lowest-numbered thread with a closed packet is served. Once a packet's first beat is offered, no other thread is served until that packet's last beat has transferred. out_last_o is high on the final beat.
- R11: After reset, out_valid_o and all overflow bits are 0, and both flag sets show empty = 1, full = 0, partial = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| pkt_end_ni | input | 1 | Packet end, active low |
| addr_i | input | $clog2(NUM_THR) | Thread select |
| data_i | input | DATA_W | Write data |
| out_ready_i | input | 1 | Downstream ready |
| out_valid_o | output | 1 | Downstream beat valid |
| out_thread_o | output | $clog2(NUM_THR) | Thread of the current beat |
| out_count_o | output | $clog2(DEPTH+1) | Word count of the current packet |
| out_data_o | output | DATA_W | Beat data, 0 for a zero-length packet |
| out_last_o | output | 1 | Final beat of the packet |
| flag_cur_empty_o | output | 1 | Empty flag, addressed thread |
| flag_cur_full_o | output | 1 | Full flag, addressed thread |
| flag_cur_part_o | output | 1 | Partial flag, addressed thread |
| flag_ded_empty_o | output | 1 | Empty flag, dedicated thread |
| flag_ded_full_o | output | 1 | Full flag, dedicated thread |
| flag_ded_part_o | output | 1 | Partial flag, dedicated thread |
| overflow_o | output | NUM_THR | Sticky per-thread overflow |

## Verification
The directed phases each separate one behaviour:
- A short packet on one thread tests that packet-end includes the final word.
- A lone packet-end tests the zero-length beat against a dropped request.
- Strobes with chip select high test that deselected inputs are ignored.
- Overfilling one thread while downstream is stalled tests that a drop is total and the overflow bit is sticky.
- A burst of zero-length packets tests the length-queue limit.

A long pseudo-random phase mixes addresses, strobes and stalled ready against a queue-based model. That phase exposes ordering and lock errors between threads, and any misplaced flag pipeline stage, because the flags are compared against status taken three edges earlier.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic partial;
  } sfe_stat_t;

  localparam sfe_stat_t SFE_STAT_RST = '{empty: 1'b1, full: 1'b0, partial: 1'b0};
endpackage

// File: rtl/sfe_thread.sv
module sfe_thread
  import sfe_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 8,
  parameter int LEN_DEPTH = 4,
  parameter int THR       = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sel_i,
  input  logic                         wr_i,
  input  logic                         pe_i,
  input  logic [DATA_W-1:0]            data_i,
  input  logic                         pop_word_i,
  input  logic                         pop_pkt_i,
  output logic [DATA_W-1:0]            head_data_o,
  output logic [$clog2(DEPTH+1)-1:0]   head_len_o,
  output logic                         pkt_avail_o,
  output sfe_stat_t                    stat_o,
  output logic                         ovf_o
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LPTR_W = $clog2(LEN_DEPTH);
  localparam int LCNT_W = $clog2(LEN_DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  len_q [LEN_DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [LPTR_W-1:0] lwp_q, lrp_q;
  logic [CNT_W-1:0]  cnt_q, open_q;
  logic [LCNT_W-1:0] lcnt_q;
  logic              word_full, len_full, ok, do_wr, do_pe, drop;

  assign word_full = (cnt_q == CNT_W'(DEPTH));
  assign len_full  = (lcnt_q == LCNT_W'(LEN_DEPTH));
  // a request is taken whole or not at all
  assign ok    = wr_i ? (!word_full && !(pe_i && len_full)) : !len_full;
  assign do_wr = sel_i && wr_i && ok;
  assign do_pe = sel_i && pe_i && ok;
  assign drop  = sel_i && (wr_i || pe_i) && !ok;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q] <= data_i;
    if (do_pe) len_q[lwp_q] <= open_q + CNT_W'(do_wr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      lwp_q  <= '0;
      lrp_q  <= '0;
      cnt_q  <= '0;
      open_q <= '0;
      lcnt_q <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (do_wr)      wp_q  <= wp_q + PTR_W'(1);
      if (pop_word_i) rp_q  <= rp_q + PTR_W'(1);
      if (do_pe)      lwp_q <= lwp_q + LPTR_W'(1);
      if (pop_pkt_i)  lrp_q <= lrp_q + LPTR_W'(1);
      cnt_q  <= cnt_q + CNT_W'(do_wr) - CNT_W'(pop_word_i);
      lcnt_q <= lcnt_q + LCNT_W'(do_pe) - LCNT_W'(pop_pkt_i);
      if (do_pe)      open_q <= '0;
      else if (do_wr) open_q <= open_q + CNT_W'(1);
      if (drop) ovf_o <= 1'b1;
    end
  end

  assign head_data_o    = mem_q[rp_q];
  assign head_len_o     = len_q[lrp_q];
  assign pkt_avail_o    = (lcnt_q != '0);
  assign stat_o.empty   = (cnt_q == '0);
  assign stat_o.full    = word_full || len_full;
  assign stat_o.partial = ((CNT_W'(DEPTH) - cnt_q) <= CNT_W'(THR));
endmodule

// File: rtl/sfe_arb.sv
module sfe_arb #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2,
  parameter int CNT_W   = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_THR-1:0]              avail_i,
  input  logic [NUM_THR-1:0][CNT_W-1:0]   len_i,
  input  logic                            ready_i,
  output logic                            valid_o,
  output logic [TID_W-1:0]                gnt_o,
  output logic [CNT_W-1:0]                count_o,
  output logic                            last_o,
  output logic [NUM_THR-1:0]              pop_word_o,
  output logic [NUM_THR-1:0]              pop_pkt_o
);
  logic             lock_q;
  logic [TID_W-1:0] cur_q, low;
  logic [CNT_W-1:0] idx_q;
  logic             fire;

  always_comb begin
    low = '0;
    for (int i = NUM_THR - 1; i >= 0; i--) if (avail_i[i]) low = TID_W'(i);
  end

  assign gnt_o   = lock_q ? cur_q : low;
  assign valid_o = avail_i[gnt_o];
  assign count_o = len_i[gnt_o];
  assign last_o  = (count_o == '0) || (idx_q == count_o - CNT_W'(1));
  assign fire    = valid_o && ready_i;

  always_comb begin
    for (int i = 0; i < NUM_THR; i++) begin
      pop_word_o[i] = fire && (gnt_o == TID_W'(i)) && (count_o != '0);
      pop_pkt_o[i]  = fire && (gnt_o == TID_W'(i)) && last_o;
    end
  end

  // lock on first offer so a stalled beat never changes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      cur_q  <= '0;
      idx_q  <= '0;
    end else if (fire && last_o) begin
      lock_q <= 1'b0;
      idx_q  <= '0;
    end else if (valid_o) begin
      lock_q <= 1'b1;
      cur_q  <= gnt_o;
      if (fire) idx_q <= idx_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sfe_flag_pipe.sv
module sfe_flag_pipe
  import sfe_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sfe_stat_t cur_i,
  input  sfe_stat_t ded_i,
  output sfe_stat_t cur_o,
  output sfe_stat_t ded_o
);
  sfe_stat_t cur_q [LAT];
  sfe_stat_t ded_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAT; i++) begin
        cur_q[i] <= SFE_STAT_RST;
        ded_q[i] <= SFE_STAT_RST;
      end
    end else begin
      cur_q[0] <= cur_i;
      ded_q[0] <= ded_i;
      for (int i = 1; i < LAT; i++) begin
        cur_q[i] <= cur_q[i-1];
        ded_q[i] <= ded_q[i-1];
      end
    end
  end

  assign cur_o = cur_q[LAT-1];
  assign ded_o = ded_q[LAT-1];
endmodule

// File: rtl/sfe_slave_fifo.sv
module sfe_slave_fifo
  import sfe_pkg::*;
#(
  parameter int NUM_THR             = 4,
  parameter int DATA_W              = 16,
  parameter int DEPTH               = 8,
  parameter int LEN_DEPTH           = 4,
  parameter int FLAG_LAT            = 3,
  parameter int DED_THR             = 0,
  parameter int PART_THR [NUM_THR]  = '{2, 2, 3, 1}
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cs_ni,
  input  logic                          wr_ni,
  input  logic                          pkt_end_ni,
  input  logic [$clog2(NUM_THR)-1:0]    addr_i,
  input  logic [DATA_W-1:0]             data_i,
  input  logic                          out_ready_i,
  output logic                          out_valid_o,
  output logic [$clog2(NUM_THR)-1:0]    out_thread_o,
  output logic [$clog2(DEPTH+1)-1:0]    out_count_o,
  output logic [DATA_W-1:0]             out_data_o,
  output logic                          out_last_o,
  output logic                          flag_cur_empty_o,
  output logic                          flag_cur_full_o,
  output logic                          flag_cur_part_o,
  output logic                          flag_ded_empty_o,
  output logic                          flag_ded_full_o,
  output logic                          flag_ded_part_o,
  output logic [NUM_THR-1:0]            overflow_o
);
  localparam int TID_W = $clog2(NUM_THR);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                          wr, pe;
  logic [NUM_THR-1:0]            avail, pop_word, pop_pkt;
  logic [NUM_THR-1:0][DATA_W-1:0] head_data;
  logic [NUM_THR-1:0][CNT_W-1:0]  head_len;
  sfe_stat_t                     stat [NUM_THR];
  sfe_stat_t                     cur_stat, cur_flag, ded_flag;

  assign wr = !cs_ni && !wr_ni;
  assign pe = !cs_ni && !pkt_end_ni;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    sfe_thread #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_DEPTH(LEN_DEPTH), .THR(PART_THR[t])
    ) u_thr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (addr_i == TID_W'(t)),
      .wr_i       (wr),
      .pe_i       (pe),
      .data_i     (data_i),
      .pop_word_i (pop_word[t]),
      .pop_pkt_i  (pop_pkt[t]),
      .head_data_o(head_data[t]),
      .head_len_o (head_len[t]),
      .pkt_avail_o(avail[t]),
      .stat_o     (stat[t]),
      .ovf_o      (overflow_o[t])
    );
  end

  sfe_arb #(.NUM_THR(NUM_THR), .TID_W(TID_W), .CNT_W(CNT_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .avail_i   (avail),
    .len_i     (head_len),
    .ready_i   (out_ready_i),
    .valid_o   (out_valid_o),
    .gnt_o     (out_thread_o),
    .count_o   (out_count_o),
    .last_o    (out_last_o),
    .pop_word_o(pop_word),
    .pop_pkt_o (pop_pkt)
  );

  assign out_data_o = (out_count_o == '0) ? '0 : head_data[out_thread_o];
  assign cur_stat   = (32'(addr_i) < NUM_THR) ? stat[addr_i] : SFE_STAT_RST;

  sfe_flag_pipe #(.LAT(FLAG_LAT)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cur_i (cur_stat),
    .ded_i (stat[DED_THR]),
    .cur_o (cur_flag),
    .ded_o (ded_flag)
  );

  assign flag_cur_empty_o = cur_flag.empty;
  assign flag_cur_full_o  = cur_flag.full;
  assign flag_cur_part_o  = cur_flag.partial;
  assign flag_ded_empty_o = ded_flag.empty;
  assign flag_ded_full_o  = ded_flag.full;
  assign flag_ded_part_o  = ded_flag.partial;
endmodule

// File: rtl/sfe_slave_fifo_chk.sv
module sfe_slave_fifo_chk #(
  parameter int NUM_THR = 4,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cs_ni,
  input logic                       wr_ni,
  input logic                       pkt_end_ni,
  input logic                       out_ready_i,
  input logic                       out_valid_o,
  input logic [$clog2(NUM_THR)-1:0] out_thread_o,
  input logic [CNT_W-1:0]           out_count_o,
  input logic [DATA_W-1:0]          out_data_o,
  input logic                       out_last_o,
  input logic                       flag_cur_empty_o,
  input logic                       flag_cur_part_o,
  input logic [NUM_THR-1:0]         overflow_o
);
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o & $past(overflow_o)) == $past(overflow_o)); // R5
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o != $past(overflow_o)) |-> $past(!cs_ni && (!wr_ni || !pkt_end_ni))); // R4
  AST_ZLP_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_count_o == '0) |-> (out_last_o && out_data_o == '0)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_thread_o)
      && $stable(out_count_o) && $stable(out_data_o))); // R9
  AST_EMPTY_NOT_PART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_cur_empty_o |-> !flag_cur_part_o); // R6
endmodule

bind sfe_slave_fifo sfe_slave_fifo_chk #(
  .NUM_THR(NUM_THR), .DATA_W(DATA_W), .CNT_W($clog2(DEPTH + 1))
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cs_ni           (cs_ni),
  .wr_ni           (wr_ni),
  .pkt_end_ni      (pkt_end_ni),
  .out_ready_i     (out_ready_i),
  .out_valid_o     (out_valid_o),
  .out_thread_o    (out_thread_o),
  .out_count_o     (out_count_o),
  .out_data_o      (out_data_o),
  .out_last_o      (out_last_o),
  .flag_cur_empty_o(flag_cur_empty_o),
  .flag_cur_part_o (flag_cur_part_o),
  .overflow_o      (overflow_o)
);

// File: tb/sfe_slave_fifo_tb.sv
module sfe_slave_fifo_tb;
  localparam int NT = 4, DEPTH = 8, LEN_DEPTH = 4, DED = 0;
  localparam int THR [NT] = '{2, 2, 3, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, pe_n = 1'b1, ready = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] data = '0;
  logic        out_valid, out_last;
  logic [1:0]  out_thread;
  logic [3:0]  out_count;
  logic [15:0] out_data;
  logic        fce, fcf, fcp, fde, fdf, fdp;
  logic [3:0]  ovf;

  always #10 clk = ~clk;

  sfe_slave_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .pkt_end_ni(pe_n),
    .addr_i(addr), .data_i(data), .out_ready_i(ready),
    .out_valid_o(out_valid), .out_thread_o(out_thread), .out_count_o(out_count),
    .out_data_o(out_data), .out_last_o(out_last),
    .flag_cur_empty_o(fce), .flag_cur_full_o(fcf), .flag_cur_part_o(fcp),
    .flag_ded_empty_o(fde), .flag_ded_full_o(fdf), .flag_ded_part_o(fdp),
    .overflow_o(ovf)
  );

  int checks = 0, errors = 0;
  logic [15:0] qw [NT][$];
  int          ql [NT][$];
  int          open_len [NT];
  bit          m_ovf [NT];
  bit          m_lock = 0;
  int          m_cur = 0, m_idx = 0;
  int          hc [3] = '{4, 4, 4};
  int          hd [3] = '{4, 4, 4};
  bit          model_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // status code: {empty, full, partial}
  function automatic int stat_of(input int t);
    int c = qw[t].size();
    int e = (c == 0);
    int f = (c == DEPTH) || (ql[t].size() == LEN_DEPTH);
    int p = ((DEPTH - c) <= THR[t]);
    return e * 4 + f * 2 + p;
  endfunction

  function automatic int sel_thr();
    if (m_lock) return m_cur;
    for (int i = 0; i < NT; i++) if (ql[i].size() != 0) return i;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst_n && model_on) begin
      int t, g, cnt;
      bit w, p, ok, v, last;
      hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = stat_of(int'(addr));
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = stat_of(DED);
      t = int'(addr);
      w = !cs_n && !wr_n;
      p = !cs_n && !pe_n;
      ok = w ? (qw[t].size() < DEPTH && !(p && ql[t].size() == LEN_DEPTH))
             : (ql[t].size() < LEN_DEPTH);
      g = sel_thr();
      v = ql[g].size() != 0;
      cnt = v ? ql[g][0] : 0;
      last = (cnt == 0) || (m_idx == cnt - 1);
      if (v && ready) begin
        if (cnt != 0) void'(qw[g].pop_front());
        if (last) begin
          void'(ql[g].pop_front());
          m_idx = 0; m_lock = 0;
        end else begin
          m_idx++; m_lock = 1; m_cur = g;
        end
      end else if (v) begin
        m_lock = 1; m_cur = g;
      end
      if ((w || p) && !ok) m_ovf[t] = 1;
      else begin
        if (w) begin qw[t].push_back(data); open_len[t]++; end
        if (p) begin ql[t].push_back(open_len[t]); open_len[t] = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      int g, cnt;
      bit v;
      g = sel_thr();
      v = ql[g].size() != 0;
      chk(out_valid == v, "R10 valid", out_valid, v);
      if (v) begin
        cnt = ql[g][0];
        chk(int'(out_thread) == g, "R10 thread", out_thread, g);
        chk(int'(out_count) == cnt, "R2 count", out_count, cnt);
        chk(out_last == ((cnt == 0) || (m_idx == cnt - 1)), "R10 last", out_last,
            (cnt == 0) || (m_idx == cnt - 1));
        if (cnt != 0) chk(out_data == qw[g][0], "R1 R9 data", out_data, qw[g][0]);
        else chk(out_data == 0, "R3 zlp data", out_data, 0);
      end
      chk(int'({fce, fcf, fcp}) == hc[2], "R6 R7 cur flags", {fce, fcf, fcp}, hc[2]);
      chk(int'({fde, fdf, fdp}) == hd[2], "R8 ded flags", {fde, fdf, fdp}, hd[2]);
      for (int i = 0; i < NT; i++)
        chk(ovf[i] == m_ovf[i], "R5 overflow", ovf[i], m_ovf[i]);
    end
  end

  task automatic drv(input logic c, input logic w, input logic p, input int a,
                     input int d, input logic r);
    @(negedge clk);
    cs_n = c; wr_n = w; pe_n = p; addr = 2'(a); data = 16'(d); ready = r;
  endtask

  task automatic idle(input int n, input logic r);
    for (int i = 0; i < n; i++) drv(1, 1, 1, 0, 0, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) begin open_len[i] = 0; m_ovf[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 0, "R11 valid after reset", out_valid, 0);
    chk({fce, fcf, fcp} == 3'b100, "R11 cur flags", {fce, fcf, fcp}, 4);
    chk({fde, fdf, fdp} == 3'b100, "R11 ded flags", {fde, fdf, fdp}, 4);
    chk(ovf == 0, "R11 overflow", ovf, 0);
    model_on = 1;

    // R1 R2: short packet on thread 0, last word carries packet end
    drv(0, 0, 1, 0, 16'h1111, 0);
    drv(0, 0, 1, 0, 16'h2222, 0);
    drv(0, 0, 0, 0, 16'h3333, 0);
    idle(2, 0);
    chk(out_valid && out_count == 3 && out_data == 16'h1111, "R2 short packet head",
        out_count, 3);
    idle(6, 1);

    // R3: zero-length packet on thread 2
    drv(0, 1, 0, 2, 0, 0);
    idle(1, 0);
    chk(out_valid && out_count == 0 && out_last && out_thread == 2, "R3 zlp beat",
        out_count, 0);
    idle(4, 1);

    // R4: strobes with chip select high on thread 3
    for (int i = 0; i < 4; i++) drv(1, 0, 0, 3, 16'hdead, 1);
    idle(0, 1);
    for (int i = 0; i < 4; i++) drv(1, 1, 1, 3, 0, 1);
    chk(out_valid == 0, "R4 deselected no packet", out_valid, 0);
    chk(fce == 1, "R4 deselected thread stays empty", fce, 1);
    chk(ovf[3] == 0, "R4 deselected no overflow", ovf[3], 0);

    // R5: overfill thread 1 while downstream stalled
    for (int i = 0; i < DEPTH + 1; i++) drv(0, 0, 1, 1, 16'h0100 + i, 0);
    drv(0, 1, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) drv(1, 1, 1, 1, 0, 0);
    chk(ovf[1] == 1, "R5 word overflow set", ovf[1], 1);
    chk(fcf == 1, "R6 full flag thread 1", fcf, 1);
    drv(0, 1, 0, 1, 0, 0);
    idle(2, 0);
    chk(out_valid && out_count == DEPTH, "R5 stored words kept", out_count, DEPTH);
    idle(DEPTH + 4, 1);
    chk(ovf[1] == 1, "R5 overflow sticky", ovf[1], 1);

    // R5: length queue limit with zero-length packets on thread 2
    for (int i = 0; i < LEN_DEPTH + 1; i++) drv(0, 1, 0, 2, 0, 0);
    idle(2, 0);
    chk(ovf[2] == 1, "R5 length queue overflow", ovf[2], 1);
    idle(LEN_DEPTH + 4, 1);

    // R9 R10: mixed traffic
    for (int i = 0; i < 2000; i++) begin
      drv(($urandom % 8) == 0, ($urandom % 3) == 0, ($urandom % 6) != 0,
          $urandom % NT, $urandom % 65536, ($urandom % 4) != 0);
    end
    idle(60, 1);
    chk(out_valid == 0, "R10 drained", out_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule